// File: doc/BRIEF.md
# Dual-Clock FIFO with Offset-Driven Status Flags

This block buffers 18-bit words between a producer on one clock and a consumer on another, unrelated clock. Storage depth is a power of two from 512 to 4096 words. Pointers cross between the two clock domains as Gray code through a chain of synchronizer flops. Each side decides fullness or emptiness from its own pointer and the synchronized copy of the other side's pointer.

Five active-low status outputs describe the fill level: empty, almost-empty, half-full, almost-full and full. The almost-empty threshold comes from an empty offset input, and the almost-full threshold from a full offset input. Both offsets are supplied by a separate offset-register block. A timing-mode pin is sampled while reset is held. Its captured value chooses one of two behaviours for the two almost flags. In the first, each almost flag is computed entirely inside one clock domain. In the second, each almost flag follows the raw pointers of both domains, so it can move on an edge of either clock.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst_n` is low on edges of both clocks, both pointers clear and `rdata` clears to 0. After reset, `empty_n` and `almost_empty_n` are 0, and `half_full_n`, `almost_full_n` and `full_n` are 1.
- R2: Words are read back in the order they were written. `rdata` takes the next word on the `rd_clk` edge that samples `re_n` low.
- R3: A write attempted while the write side sees DEPTH words stored is dropped. The write pointer does not move, and `full_n` stays 0.
- R4: A read attempted while the read side sees no words is dropped. The read pointer does not move, and `rdata` keeps its previous value.
- R5: `empty_n` is 1 whenever at least one word is stored. `almost_empty_n` is 0 while the count is at most `empty_off` and 1 above it.
- R6: `half_full_n` is 0 exactly when the count exceeds DEPTH/2, for example 257 or more words at DEPTH 512.
- R7: `almost_full_n` is 0 when the count is at least DEPTH minus `full_off`. `full_n` is 0 only at exactly DEPTH words, and `almost_full_n` and `half_full_n` are also 0 at that point.
- R8: With timing mode 0, `almost_empty_n` moves only on `rd_clk` edges and `almost_full_n` only on `wr_clk` edges. A write is therefore seen by almost-empty only after the synchronizer delay, and a read is seen by almost-full only after the synchronizer delay.
- R9: With timing mode 1, `almost_empty_n` rises directly after the `wr_clk` edge that lifts the count above `empty_off`. `almost_full_n` rises directly after the `rd_clk` edge that drops the count below DEPTH minus `full_off`.
- R10: The timing mode is the value of `async_mode_i` captured while `rst_n` is low. Changing `async_mode_i` after reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| async_mode_i | input | 1 | Almost-flag timing select: 1 selects both-clock timing. Captured during reset |
| we_n | input | 1 | Active-low write enable |
| wdata | input | WORD_W (18) | Word to store |
| re_n | input | 1 | Active-low read enable |
| rdata | output | WORD_W (18) | Registered read word |
| empty_off | input | AW (9) | Almost-empty offset, in words |
| full_off | input | AW (9) | Almost-full offset, in words |
| full_n | output | 1 | Low when DEPTH words are stored |
| almost_full_n | output | 1 | Low at or above DEPTH minus `full_off` |
| half_full_n | output | 1 | Low above DEPTH/2 |
| almost_empty_n | output | 1 | Low at or below `empty_off` |
| empty_n | output | 1 | Low when no word is stored |

## Verification
The flags that a domain derives from its own pointer change immediately after that domain's clock edge:
- `full_n`, `half_full_n` and the mode-0 `almost_full_n` after a write;
- `empty_n` and the mode-0 `almost_empty_n` after a read;
- `rdata`, one registered stage after the sampling `rd_clk` edge.

Those same flags see an event from the other domain only after two edges of their own clock. In mode 1, both almost flags respond directly after an edge of either clock.

Checks for the immediate responses sample 1 ns after the edge that caused them. Such an instant lies before any edge of the other clock could have passed a synchronizer. Level checks wait for eight read-clock edges after the last stimulus, which spans every synchronizer path in both directions.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
   localparam int MIN_DEPTH = 512;
   localparam int MAX_DEPTH = 4096;
   localparam int PTR_MAX_W = 16;

   function automatic logic [PTR_MAX_W-1:0] bin_to_gray(input logic [PTR_MAX_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PTR_MAX_W-1:0] gray_to_bin(input logic [PTR_MAX_W-1:0] g);
      logic [PTR_MAX_W-1:0] b;
      b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
      for (int i = PTR_MAX_W-2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction
endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
module fifo_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_stage_err
      $error("fifo_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_dpram.sv
`timescale 1ns/1ps
module fifo_dpram #(
   parameter int W  = 18,
   parameter int AW = 9
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int WORDS = 1 << AW;

   logic [W-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
module prog_flag_fifo #(
   parameter  int WORD_W      = 18,
   parameter  int DEPTH       = 512,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              async_mode_i,
   input  logic              we_n,
   input  logic [WORD_W-1:0] wdata,
   input  logic              re_n,
   output logic [WORD_W-1:0] rdata,
   input  logic [AW-1:0]     empty_off,
   input  logic [AW-1:0]     full_off,
   output logic              full_n,
   output logic              almost_full_n,
   output logic              half_full_n,
   output logic              almost_empty_n,
   output logic              empty_n
);
   import fifo_pkg::*;

   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

   if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH || (1 << AW) != DEPTH) begin : g_depth_err
      $error("DEPTH must be a power of two between 512 and 4096");
   end
   if (WORD_W < 1) begin : g_width_err
      $error("WORD_W must be positive");
   end

   // ---------------- write domain ----------------
   logic [CW-1:0] wptr_bin, wptr_nxt, wgray, rgray_w, rptr_w;
   logic [CW-1:0] wcnt, af_lim;
   logic          wfull, wr_go, mode_q;

   always_ff @(posedge wr_clk) begin
      if (!rst_n) mode_q <= async_mode_i;
   end

   assign rptr_w   = CW'(gray_to_bin(PTR_MAX_W'(rgray_w)));
   assign wcnt     = wptr_bin - rptr_w;
   assign wfull    = (wcnt == FULL_CNT);
   assign wr_go    = !we_n && !wfull;
   assign wptr_nxt = wptr_bin + 1'b1;

   always_ff @(posedge wr_clk) begin
      if (!rst_n) begin
         wptr_bin <= '0;
         wgray    <= '0;
      end else if (wr_go) begin
         wptr_bin <= wptr_nxt;
         wgray    <= CW'(bin_to_gray(PTR_MAX_W'(wptr_nxt)));
      end
   end

   // ---------------- read domain ----------------
   logic [CW-1:0] rptr_bin, rptr_nxt, rgray, wgray_r, wptr_r, rcnt, ae_lim;
   logic          rempty, rd_go;

   assign wptr_r   = CW'(gray_to_bin(PTR_MAX_W'(wgray_r)));
   assign rcnt     = wptr_r - rptr_bin;
   assign rempty   = (rcnt == '0);
   assign rd_go    = !re_n && !rempty;
   assign rptr_nxt = rptr_bin + 1'b1;

   always_ff @(posedge rd_clk) begin
      if (!rst_n) begin
         rptr_bin <= '0;
         rgray    <= '0;
      end else if (rd_go) begin
         rptr_bin <= rptr_nxt;
         rgray    <= CW'(bin_to_gray(PTR_MAX_W'(rptr_nxt)));
      end
   end

   // ---------------- crossings and storage ----------------
   fifo_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

   fifo_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

   fifo_dpram #(.W(WORD_W), .AW(AW)) u_ram (
      .wclk(wr_clk), .we(wr_go), .waddr(wptr_bin[AW-1:0]), .wdata(wdata),
      .rclk(rd_clk), .rst_n(rst_n), .re(rd_go), .raddr(rptr_bin[AW-1:0]),
      .rdata(rdata));

   // ---------------- flags ----------------
   logic [CW-1:0] raw_cnt;
   logic          af_local, ae_local, af_raw, ae_raw;

   assign af_lim   = FULL_CNT - {1'b0, full_off};
   assign ae_lim   = {1'b0, empty_off};
   assign raw_cnt  = wptr_bin - rptr_bin;

   assign af_local = (wcnt >= af_lim);
   assign ae_local = (rcnt <= ae_lim);
   assign af_raw   = (raw_cnt >= af_lim);
   assign ae_raw   = (raw_cnt <= ae_lim);

   assign full_n         = !wfull;
   assign half_full_n    = !(wcnt > HALF_CNT);
   assign empty_n        = !rempty;
   assign almost_full_n  = mode_q ? !af_raw : !af_local;
   assign almost_empty_n = mode_q ? !ae_raw : !ae_local;

   // ---------------- assertions ----------------
   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!we_n && wfull) |=> $stable(wptr_bin)) else $error("write accepted while full"); // R3
   AST_CNT_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wcnt <= FULL_CNT) else $error("write-side count beyond depth"); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!re_n && rempty) |=> ($stable(rptr_bin) && $stable(rdata))) else $error("read accepted while empty"); // R4
   AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray))) else $error("write Gray pointer moved more than one bit"); // R2
   AST_FULL_NESTED: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!mode_q && !full_n) |-> (!almost_full_n && !half_full_n)) else $error("full without lower flags"); // R7
   AST_EMPTY_NESTED: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!mode_q && !empty_n) |-> !almost_empty_n) else $error("empty without almost-empty"); // R5
   AST_MODE_HELD: assert property (@(posedge wr_clk) disable iff (!rst_n)
      rst_n |=> $stable(mode_q)) else $error("timing mode changed outside reset"); // R10
endmodule

// File: tb/prog_flag_fifo_tb.sv
`timescale 1ns/1ps
module prog_flag_fifo_tb;
   localparam int DEPTH = 512;
   localparam int AW    = 9;
   localparam int W     = 18;

   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          rst_n = 1'b0, async_mode_i = 1'b0;
   logic          we_n = 1'b1, re_n = 1'b1;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic [AW-1:0] empty_off = 9'd10, full_off = 9'd20;
   logic          full_n, almost_full_n, half_full_n, almost_empty_n, empty_n;

   always #2.5 wr_clk = ~wr_clk;
   always #3.5 rd_clk = ~rd_clk;

   prog_flag_fifo #(.WORD_W(W), .DEPTH(DEPTH)) u_dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .async_mode_i(async_mode_i),
      .we_n(we_n), .wdata(wdata), .re_n(re_n), .rdata(rdata),
      .empty_off(empty_off), .full_off(full_off),
      .full_n(full_n), .almost_full_n(almost_full_n), .half_full_n(half_full_n),
      .almost_empty_n(almost_empty_n), .empty_n(empty_n));

   int total = 0, fails = 0, dseq = 0;
   logic [W-1:0] model [$];
   logic [W-1:0] last_rd = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic settle();
      repeat (8) @(posedge rd_clk);
      #1;
   endtask

   task automatic do_reset(input bit mode);
      async_mode_i = mode;
      rst_n = 1'b0;
      repeat (5) @(posedge rd_clk);
      @(posedge wr_clk); #1;
      rst_n = 1'b1;
      model.delete();
      last_rd = '0;
      settle();
   endtask

   task automatic wr_words(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge wr_clk); #1;
         we_n  = 1'b0;
         wdata = W'(dseq * 37 + 5);
         dseq++;
         if (model.size() < DEPTH) model.push_back(wdata);
      end
      @(posedge wr_clk); #1;
      we_n = 1'b1;
   endtask

   task automatic rd_words(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge rd_clk); #1;
         re_n = 1'b0;
         @(posedge rd_clk); #1;
         re_n = 1'b1;
         if (model.size() > 0) begin
            last_rd = model.pop_front();
            chk(rdata == last_rd, "R2 read order", int'(rdata), int'(last_rd));
         end else begin
            chk(rdata == last_rd, "R4 empty read holds data", int'(rdata), int'(last_rd));
         end
      end
   endtask

   function automatic logic [4:0] flags();
      return {full_n, almost_full_n, half_full_n, almost_empty_n, empty_n};
   endfunction

   // Entry: {read?, word count, expected {full,af,hf,ae,empty}}; offsets 10 and 20.
   localparam logic [15:0] TBL [15] = '{
      {1'b0, 10'd1,   5'b11101}, {1'b0, 10'd9,   5'b11101}, {1'b0, 10'd1,   5'b11111},
      {1'b0, 10'd245, 5'b11111}, {1'b0, 10'd1,   5'b11011}, {1'b0, 10'd234, 5'b11011},
      {1'b0, 10'd1,   5'b10011}, {1'b0, 10'd19,  5'b10011}, {1'b0, 10'd1,   5'b00011},
      {1'b1, 10'd1,   5'b10011}, {1'b1, 10'd20,  5'b11011}, {1'b1, 10'd235, 5'b11111},
      {1'b1, 10'd245, 5'b11111}, {1'b1, 10'd1,   5'b11101}, {1'b1, 10'd10,  5'b11100}
   };

   task automatic timing_probe(input bit async_exp, input string tag);
      // offsets: empty 0, full 1 -> almost-full limit is DEPTH-1
      wr_words(1);
      chk(almost_empty_n == async_exp, {tag, " almost-empty right after write"}, almost_empty_n, async_exp);
      settle();
      chk(almost_empty_n == 1'b1, "R5 almost-empty after settle", almost_empty_n, 1);
      rd_words(1);
      chk(almost_empty_n == 1'b0, "R8 almost-empty low right after read", almost_empty_n, 0);
      settle();
      wr_words(DEPTH - 2);
      settle();
      chk(almost_full_n == 1'b1, "R7 below full limit", almost_full_n, 1);
      wr_words(1);
      chk(almost_full_n == 1'b0, "R8 almost-full low right after write", almost_full_n, 0);
      settle();
      rd_words(1);
      chk(almost_full_n == async_exp, {tag, " almost-full right after read"}, almost_full_n, async_exp);
      settle();
      chk(almost_full_n == 1'b1, "R7 almost-full after settle", almost_full_n, 1);
      rd_words(DEPTH - 2);
      settle();
      chk(empty_n == 1'b0, "R5 drained", empty_n, 0);
   endtask

   bit done = 1'b0;

   initial begin
      #1_000_000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);
      chk(flags() == 5'b11100, "R1 reset flags", flags(), 5'b11100);
      chk(rdata == '0, "R1 reset rdata", int'(rdata), 0);

      foreach (TBL[k]) begin
         if (TBL[k][15]) rd_words(int'(TBL[k][14:5]));
         else            wr_words(int'(TBL[k][14:5]));
         settle();
         chk(flags()[1:0] == TBL[k][1:0], "R5 empty/almost-empty", flags(), TBL[k][4:0]);
         chk(flags()[2] == TBL[k][2], "R6 half-full", flags(), TBL[k][4:0]);
         chk(flags()[4:3] == TBL[k][4:3], "R7 full/almost-full", flags(), TBL[k][4:0]);
      end

      // R4: reads while empty
      rd_words(3);
      chk(empty_n == 1'b0, "R4 still empty", empty_n, 0);
      wr_words(1);
      settle();
      rd_words(1);
      settle();
      chk(empty_n == 1'b0, "R4 empty after single word", empty_n, 0);

      // R3: writes while full are dropped
      wr_words(DEPTH);
      settle();
      chk(full_n == 1'b0, "R3 full reached", full_n, 0);
      wr_words(3);
      settle();
      chk(full_n == 1'b0, "R3 still full after extra writes", full_n, 0);
      chk(model.size() == DEPTH, "R3 model depth", model.size(), DEPTH);
      rd_words(DEPTH);
      settle();
      chk(flags() == 5'b11100, "R3 drained exactly depth words", flags(), 5'b11100);

      // R8: local-domain timing
      empty_off = 9'd0;
      full_off  = 9'd1;
      settle();
      timing_probe(1'b0, "R8");

      // R1 reset from a non-empty state, R9/R10 both-clock timing
      wr_words(5);
      settle();
      do_reset(1'b1);
      chk(flags() == 5'b11100, "R1 reset clears stored words", flags(), 5'b11100);
      chk(rdata == '0, "R1 rdata cleared", int'(rdata), 0);
      async_mode_i = 1'b0;
      settle();
      timing_probe(1'b1, "R9 R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule